// File: doc/BRIEF.md
# Endian-Aware Load/Store Byte-Lane Aligner

This block sits between a processor's load/store unit and a naturally aligned memory element, 64 bits wide by default. For each accepted request it works out which byte lanes of the element take part, given the low physical address bits, a byte-count code and the active endianness. It then moves data between those lanes and a right-justified register view.

On data loads, the right-justified bytes read from memory are placed into their lanes of the element. On stores, the bytes taken from the element lanes are right-justified for the write, and a byte-enable mask marks the lanes used. On instruction fetches, the fetched parcel is extracted from the element at a byte index derived from the virtual address. An optional reverse-endian mode XORs the low physical address bits before anything else is done. An access that would run past the end of the element is suppressed and flagged. A fetch from a misaligned address is suppressed and flagged too.

Requests use a valid/ready handshake. Each result is registered and is presented in the cycle after the request is accepted. It stays held until the consumer takes it.

Top module: `lane_aligner`

## Requirements
- R1: The length code `req_len` is the byte count minus one (0 is 1 byte, 1 is 2 bytes, 3 is 4 bytes, 7 is 8 bytes, and 2, 4, 5, 6 are 3, 5, 6, 7 bytes). For a data load (`req_op` = 0 or 3) in little-endian mode, `rsp_load_data` equals the low (code+1) bytes of `req_mem_data`, shifted left by 8 × offset bits. All other bits are zero.
- R2: With `req_big_endian` = 1, the load and store shift is 8 × ((7 − offset) − code) bits instead of 8 × offset.
- R3: For a store (`req_op` = 1), `rsp_store_data` equals `req_store_data` shifted right by the same shift amount, keeping only the low (code+1) bytes.
- R4: For a store, `rsp_byte_en` has exactly code+1 consecutive bits set. The lowest set bit is lane shift/8. Byte-enable bit i refers to data bits [8i+7:8i].
- R5: When offset + code > 7, `rsp_bound_err` is 1. In that case `rsp_byte_en`, `rsp_load_data`, `rsp_store_data` and `rsp_fetch_data` are all zero.
- R6: The offset is `req_paddr_lo` when `req_reverse_endian` = 0. When it is 1, the offset is `req_paddr_lo` XOR (7 XOR code). The offset used is reported on `rsp_mem_offset`.
- R7: For a fetch (`req_op` = 2), `rsp_fetch_err` is 1 when offset bits [1:0] are nonzero, unless offset bit 0 is 0 and `req_vaddr_lo` bit 0 is 1. A flagged fetch returns zero data. Non-fetch requests never set `rsp_fetch_err`.
- R8: For an error-free fetch, `rsp_fetch_data` equals `req_mem_data` shifted right by 8 × idx, keeping the low (code+1) bytes. Here idx is `req_vaddr_lo`, XORed with (7 XOR code) when `req_big_endian` = 1.
- R9: `req_ready` is 1 when no result is pending or `rsp_ready` is 1. An accepted request gives `rsp_valid` = 1 in the next cycle. A result that is not taken holds all its values unchanged.
- R10: After synchronous reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 data load, 1 store, 2 instruction fetch, 3 data load |
| req_len | input | 3 | Byte count minus one |
| req_paddr_lo | input | 3 | Low physical address bits |
| req_vaddr_lo | input | 3 | Low virtual address bits (fetch index and exception rule) |
| req_big_endian | input | 1 | Big-endian lane numbering |
| req_reverse_endian | input | 1 | Apply reverse-endian address XOR |
| req_mem_data | input | 64 | Load: right-justified bytes read; fetch: whole element |
| req_store_data | input | 64 | Store data in element lanes |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_mem_offset | output | 3 | Offset after the reverse-endian XOR |
| rsp_load_data | output | 64 | Load bytes placed in element lanes |
| rsp_store_data | output | 64 | Store bytes right-justified for the write |
| rsp_byte_en | output | 8 | Store lane enables |
| rsp_fetch_data | output | 64 | Extracted fetch parcel |
| rsp_bound_err | output | 1 | Access crosses the element boundary |
| rsp_fetch_err | output | 1 | Misaligned instruction fetch |

## Verification
Some properties are checked by the assertions on every cycle. These are: a result that is not taken keeps all its values; an accepted request always produces a result in the next cycle; any nonzero byte-enable has as many bits set as the length code asks for; and a flagged result carries no data and no enables. Only the bench's sweep can show the correct lane placement. It covers every operation, length code, offset, endianness and reverse-endian setting, and compares each result with arithmetic values. The stall scenario shows the handshake under back-pressure.

// File: rtl/lane_pkg.sv
package lane_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FETCH = 2'd2,
    OP_LOAD2 = 2'd3
  } lane_op_e;

endpackage

// File: rtl/lane_offset_calc.sv
module lane_offset_calc #(
  parameter int ELEM_BYTES = 8,
  localparam int OFF_W = $clog2(ELEM_BYTES)
) (
  input  logic [OFF_W-1:0] paddr_lo,
  input  logic [OFF_W-1:0] vaddr_lo,
  input  logic [OFF_W-1:0] len_code,
  input  logic             big_endian,
  input  logic             reverse_endian,
  input  logic             is_fetch,
  output logic [OFF_W-1:0] eff_off,
  output logic [OFF_W-1:0] shift_lanes,
  output logic [OFF_W-1:0] fetch_idx,
  output logic             bound_err,
  output logic             fetch_err
);

  localparam logic [OFF_W-1:0] MASK   = OFF_W'(ELEM_BYTES - 1);
  localparam logic [OFF_W:0]   MASK_X = (OFF_W+1)'(ELEM_BYTES - 1);

  logic [OFF_W-1:0] flip_key;
  logic [OFF_W:0]   span_end;
  logic [OFF_W:0]   be_base;

  always_comb begin
    flip_key  = MASK ^ len_code;
    eff_off   = reverse_endian ? (paddr_lo ^ flip_key) : paddr_lo;
    span_end  = {1'b0, eff_off} + {1'b0, len_code};
    bound_err = span_end > MASK_X;
    be_base   = MASK_X - span_end;
    shift_lanes = big_endian ? be_base[OFF_W-1:0] : eff_off;
    fetch_idx = big_endian ? (vaddr_lo ^ flip_key) : vaddr_lo;
    fetch_err = is_fetch && (eff_off[1:0] != 2'b00) &&
                (eff_off[0] || !vaddr_lo[0]);
  end

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int ELEM_BYTES = 8,
  localparam int OFF_W  = $clog2(ELEM_BYTES),
  localparam int DATA_W = 8 * ELEM_BYTES
) (
  input  logic [DATA_W-1:0]     mem_data,
  input  logic [DATA_W-1:0]     store_data,
  input  logic [OFF_W-1:0]      len_code,
  input  logic [OFF_W-1:0]      shift_lanes,
  input  logic [OFF_W-1:0]      fetch_idx,
  output logic [DATA_W-1:0]     load_lanes,
  output logic [DATA_W-1:0]     store_bytes,
  output logic [ELEM_BYTES-1:0] byte_en,
  output logic [DATA_W-1:0]     fetch_bytes
);

  logic [ELEM_BYTES-1:0] keep;
  logic [DATA_W-1:0]     byte_mask;
  logic [OFF_W+2:0]      shift_bits;
  logic [OFF_W+2:0]      fetch_bits;

  for (genvar b = 0; b < ELEM_BYTES; b++) begin : g_lane
    assign keep[b] = (len_code >= OFF_W'(b));
    assign byte_mask[8*b +: 8] = {8{keep[b]}};
  end

  always_comb begin
    shift_bits  = {shift_lanes, 3'b000};
    fetch_bits  = {fetch_idx, 3'b000};
    load_lanes  = (mem_data & byte_mask) << shift_bits;
    store_bytes = (store_data >> shift_bits) & byte_mask;
    byte_en     = keep << shift_lanes;
    fetch_bytes = (mem_data >> fetch_bits) & byte_mask;
  end

endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
  import lane_pkg::*;
#(
  parameter int ELEM_BYTES = 8,
  localparam int OFF_W  = $clog2(ELEM_BYTES),
  localparam int DATA_W = 8 * ELEM_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_op,
  input  logic [OFF_W-1:0]      req_len,
  input  logic [OFF_W-1:0]      req_paddr_lo,
  input  logic [OFF_W-1:0]      req_vaddr_lo,
  input  logic                  req_big_endian,
  input  logic                  req_reverse_endian,
  input  logic [DATA_W-1:0]     req_mem_data,
  input  logic [DATA_W-1:0]     req_store_data,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [OFF_W-1:0]      rsp_mem_offset,
  output logic [DATA_W-1:0]     rsp_load_data,
  output logic [DATA_W-1:0]     rsp_store_data,
  output logic [ELEM_BYTES-1:0] rsp_byte_en,
  output logic [DATA_W-1:0]     rsp_fetch_data,
  output logic                  rsp_bound_err,
  output logic                  rsp_fetch_err
);

  lane_op_e op;
  logic is_store, is_fetch, is_load, ok, accept;

  logic [OFF_W-1:0]      eff_off, shift_lanes, fetch_idx;
  logic                  bound_err, fetch_err;
  logic [DATA_W-1:0]     load_lanes, store_bytes, fetch_bytes;
  logic [ELEM_BYTES-1:0] byte_en;

  logic                  valid_q;
  logic [OFF_W-1:0]      len_q;

  assign op       = lane_op_e'(req_op);
  assign is_store = (op == OP_STORE);
  assign is_fetch = (op == OP_FETCH);
  assign is_load  = !is_store && !is_fetch;

  lane_offset_calc #(.ELEM_BYTES(ELEM_BYTES)) u_calc (
    .paddr_lo       (req_paddr_lo),
    .vaddr_lo       (req_vaddr_lo),
    .len_code       (req_len),
    .big_endian     (req_big_endian),
    .reverse_endian (req_reverse_endian),
    .is_fetch       (is_fetch),
    .eff_off        (eff_off),
    .shift_lanes    (shift_lanes),
    .fetch_idx      (fetch_idx),
    .bound_err      (bound_err),
    .fetch_err      (fetch_err)
  );

  lane_shifter #(.ELEM_BYTES(ELEM_BYTES)) u_shift (
    .mem_data    (req_mem_data),
    .store_data  (req_store_data),
    .len_code    (req_len),
    .shift_lanes (shift_lanes),
    .fetch_idx   (fetch_idx),
    .load_lanes  (load_lanes),
    .store_bytes (store_bytes),
    .byte_en     (byte_en),
    .fetch_bytes (fetch_bytes)
  );

  assign ok        = !bound_err && !fetch_err;
  assign req_ready = !valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q        <= 1'b0;
      len_q          <= '0;
      rsp_mem_offset <= '0;
      rsp_load_data  <= '0;
      rsp_store_data <= '0;
      rsp_byte_en    <= '0;
      rsp_fetch_data <= '0;
      rsp_bound_err  <= 1'b0;
      rsp_fetch_err  <= 1'b0;
    end else if (accept) begin
      valid_q        <= 1'b1;
      len_q          <= req_len;
      rsp_mem_offset <= eff_off;
      rsp_load_data  <= (ok && is_load)  ? load_lanes  : '0;
      rsp_store_data <= (ok && is_store) ? store_bytes : '0;
      rsp_byte_en    <= (ok && is_store) ? byte_en     : '0;
      rsp_fetch_data <= (ok && is_fetch) ? fetch_bytes : '0;
      rsp_bound_err  <= bound_err;
      rsp_fetch_err  <= fetch_err;
    end else if (rsp_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign rsp_valid = valid_q;

endmodule

// File: rtl/lane_aligner_chk.sv
module lane_aligner_chk #(
  parameter int ELEM_BYTES = 8,
  localparam int OFF_W  = $clog2(ELEM_BYTES),
  localparam int DATA_W = 8 * ELEM_BYTES
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [OFF_W-1:0]      len_q,
  input logic [DATA_W-1:0]     rsp_load_data,
  input logic [DATA_W-1:0]     rsp_store_data,
  input logic [ELEM_BYTES-1:0] rsp_byte_en,
  input logic [DATA_W-1:0]     rsp_fetch_data,
  input logic                  rsp_bound_err,
  input logic                  rsp_fetch_err
);

  a_r9_accept_gives_result: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid);

  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_load_data) &&
      $stable(rsp_store_data) && $stable(rsp_byte_en) && $stable(rsp_fetch_data));

  a_r4_enable_count: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && (rsp_byte_en != '0) |-> $countones(rsp_byte_en) == int'(len_q) + 1);

  a_r5_bound_quiet: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_bound_err |-> rsp_byte_en == '0 && rsp_load_data == '0 &&
      rsp_store_data == '0 && rsp_fetch_data == '0);

  a_r7_fetch_quiet: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fetch_err |-> rsp_fetch_data == '0 && rsp_byte_en == '0);

endmodule

bind lane_aligner lane_aligner_chk #(.ELEM_BYTES(ELEM_BYTES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .len_q          (len_q),
  .rsp_load_data  (rsp_load_data),
  .rsp_store_data (rsp_store_data),
  .rsp_byte_en    (rsp_byte_en),
  .rsp_fetch_data (rsp_fetch_data),
  .rsp_bound_err  (rsp_bound_err),
  .rsp_fetch_err  (rsp_fetch_err)
);

// File: tb/test_lane_aligner.sv
`timescale 1ns/1ps
module test_lane_aligner;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [2:0]  req_len = '0;
  logic [2:0]  req_paddr_lo = '0;
  logic [2:0]  req_vaddr_lo = '0;
  logic        req_big_endian = 1'b0;
  logic        req_reverse_endian = 1'b0;
  logic [63:0] req_mem_data = '0;
  logic [63:0] req_store_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [2:0]  rsp_mem_offset;
  logic [63:0] rsp_load_data, rsp_store_data, rsp_fetch_data;
  logic [7:0]  rsp_byte_en;
  logic        rsp_bound_err, rsp_fetch_err;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_aligner i_lane_aligner (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_len(req_len), .req_paddr_lo(req_paddr_lo),
    .req_vaddr_lo(req_vaddr_lo), .req_big_endian(req_big_endian),
    .req_reverse_endian(req_reverse_endian), .req_mem_data(req_mem_data),
    .req_store_data(req_store_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_mem_offset(rsp_mem_offset), .rsp_load_data(rsp_load_data),
    .rsp_store_data(rsp_store_data), .rsp_byte_en(rsp_byte_en),
    .rsp_fetch_data(rsp_fetch_data), .rsp_bound_err(rsp_bound_err),
    .rsp_fetch_err(rsp_fetch_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_txn(input int op, input int len, input int pa, input int va,
                         input int big, input int rev,
                         input logic [63:0] mem, input logic [63:0] sd);
    int eff, bytes, sh, idx;
    bit berr, ferr, ok;
    logic [63:0] lmask, e_load, e_store, e_fetch;
    logic [7:0]  e_be;
    eff   = rev ? (pa ^ (7 ^ len)) : pa;
    bytes = len + 1;
    berr  = (eff + len) > 7;
    sh    = big ? (7 - eff - len) : eff;
    if (sh < 0) sh = 0;
    idx   = big ? (va ^ (7 ^ len)) : va;
    ferr  = (op == 2) && ((eff % 4) != 0) && (((eff % 2) == 1) || ((va % 2) == 0));
    ok    = !berr && !ferr;
    lmask = (bytes == 8) ? '1 : ((64'd1 << (8 * bytes)) - 64'd1);
    e_load  = (ok && (op == 0 || op == 3)) ? ((mem & lmask) << (8 * sh)) : '0;
    e_store = (ok && op == 1) ? ((sd >> (8 * sh)) & lmask) : '0;
    e_be    = (ok && op == 1) ? 8'(((1 << bytes) - 1) << sh) : '0;
    e_fetch = (ok && op == 2) ? ((mem >> (8 * idx)) & lmask) : '0;

    @(negedge clk);
    req_op = 2'(op); req_len = 3'(len); req_paddr_lo = 3'(pa); req_vaddr_lo = 3'(va);
    req_big_endian = 1'(big); req_reverse_endian = 1'(rev);
    req_mem_data = mem; req_store_data = sd;
    req_valid = 1'b1; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, "R9 result next cycle", 64'(rsp_valid), 64'd1);
    check(rsp_mem_offset == 3'(eff), "R6 offset", 64'(rsp_mem_offset), 64'(eff));
    check(rsp_bound_err == berr, "R5 boundary flag", 64'(rsp_bound_err), 64'(berr));
    check(rsp_fetch_err == ferr, "R7 fetch flag", 64'(rsp_fetch_err), 64'(ferr));
    if (big) check(rsp_load_data == e_load, "R2 big-endian load", rsp_load_data, e_load);
    else     check(rsp_load_data == e_load, "R1 load lanes", rsp_load_data, e_load);
    check(rsp_store_data == e_store, "R3 store bytes", rsp_store_data, e_store);
    check(rsp_byte_en == e_be, "R4 byte enables", 64'(rsp_byte_en), 64'(e_be));
    check(rsp_fetch_data == e_fetch, "R8 fetch data", rsp_fetch_data, e_fetch);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(rsp_valid == 1'b0, "R10 reset valid", 64'(rsp_valid), 64'd0);
    check(req_ready == 1'b1, "R10 reset ready", 64'(req_ready), 64'd1);

    // R1..R8: sweep every op, length code, offset, endianness and reverse mode
    for (int op = 0; op < 4; op++)
      for (int len = 0; len < 8; len++)
        for (int pa = 0; pa < 8; pa++)
          for (int big = 0; big < 2; big++)
            for (int rev = 0; rev < 2; rev++)
              for (int vf = 0; vf < 2; vf++)
                run_txn(op, len, pa, pa ^ vf, big, rev,
                        {$urandom, $urandom}, {$urandom, $urandom});

    // R9: back-pressure holds the result and blocks new requests
    @(negedge clk);
    req_op = 2'd0; req_len = 3'd7; req_paddr_lo = 3'd0; req_big_endian = 1'b0;
    req_reverse_endian = 1'b0; req_mem_data = 64'h0123_4567_89ab_cdef;
    req_valid = 1'b1; rsp_ready = 1'b0;
    @(negedge clk);
    held = rsp_load_data;
    check(held == 64'h0123_4567_89ab_cdef, "R9 first result", held, 64'h0123_4567_89ab_cdef);
    req_mem_data = 64'hffff_0000_ffff_0000;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R9 ready low while stalled", 64'(req_ready), 64'd0);
      check(rsp_valid == 1'b1 && rsp_load_data == held, "R9 held result",
            rsp_load_data, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_load_data == 64'hffff_0000_ffff_0000, "R9 queued request after release",
          rsp_load_data, 64'hffff_0000_ffff_0000);
    req_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 drained", 64'(rsp_valid), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule